// File: doc/BRIEF.md
# Buffered Factory-Program Host Sequencer

This block sits on the host side of a parallel flash device. It runs the fast buffered factory-program procedure for one block. A single `start` pulse supplies a word-aligned start address and a word count. The sequencer then does the following, in order:

- It writes a setup command and a confirm command.
- It reads the status byte until the device reports ready.
- It streams the caller's words through a valid/ready input. Each 32-word buffer is written to that buffer's own first address, and a status poll comes before every write after the first.
- It pads the last buffer with all-ones words.
- It ends the program phase with a write that lands outside the target block.
- It waits for ready once more and checks the final status byte for error bits.

The result is a one-cycle `done` or `err` pulse. The error code and the status byte that decided the outcome stay on the outputs until the next accepted request. A request that would misbehave on the device is refused before any bus cycle.

The device bus has a write strobe and a read strobe. Read status is sampled on the clock edge where the read strobe is high. Status bit 7 means the device is ready. Status bit 4 means setup failed. Status bit 0 means the device is busy taking the last word.

Top module: `fprog_seq`

## Requirements
- R1: A start whose address has any of its low five bits set is refused. `err` pulses in the cycle after the start edge with code 1, and no bus write or read occurs.
- R2: A start with a word count of zero, or with (address offset inside the 65536-word block + count) above 65536, is refused. `err` pulses with code 2 and no bus cycle occurs.
- R3: An accepted start first writes the setup value 0x0080 and then the confirm value 0x00D0 to the start address, on back-to-back cycles. After that the sequencer reads status until bit 7 is 1.
- R4: If status bit 4 is 1 on the read that shows bit 7 set, the run ends with code 3. That status byte is captured and no data write follows.
- R5: Words of buffer n, counting from 0, are all written to start address + 32·n. The first data write follows the ready read directly.
- R6: From the second write after confirm onward, every bus write is preceded by at least one status read. No such write occurs before a read has shown bit 0 clear.
- R7: Each buffer holds exactly 32 writes. Positions past the supplied count carry 0xFFFF.
- R8: After the last buffer there is exactly one write of 0xFFFF to the start address XOR 0x10000. That address is outside the block.
- R9: After that write, status is read until bit 7 is 1. If any of bits 5, 4, 3 or 1 is then set, the run ends with code 5; otherwise `done` pulses with code 0. Either way the status byte is captured.
- R10: 1000 consecutive status reads without the awaited condition end the run with code 4, on the 1000th read.
- R11: `wr_ready` is high only while a supplied word may be written. When `wr_valid` is low the sequencer waits without a bus cycle. Words reach the bus in arrival order.
- R12: After reset, `busy`, `done`, `err`, `wr_ready` and both bus strobes are low. `done` and `err` are single-cycle pulses. A start that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, sampled while idle |
| start_addr | input | 24 | Word address of the first buffer |
| word_count | input | 17 | Number of supplied words |
| wr_data | input | 16 | Supplied data word |
| wr_valid | input | 1 | Supplied word is present |
| wr_ready | output | 1 | Sequencer takes the word this cycle |
| bus_addr | output | 24 | Device word address |
| bus_wdata | output | 16 | Device write data |
| bus_we | output | 1 | Device write strobe |
| bus_re | output | 1 | Device status read strobe |
| bus_rstat | input | 8 | Status byte returned by the device |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Success pulse |
| err | output | 1 | Failure pulse |
| err_code | output | 3 | Outcome code, held until the next accepted request |
| status_cap | output | 8 | Status byte that decided the outcome |

## Verification
A wrong buffer index or address register shows up on the bus in the cycle of the next data write. The symptom is a misplaced pad word, a shifted buffer address, or a 33rd write where the 32-word buffer should have ended.

A stale end-of-data flag shows as an early or missing out-of-block write. That write lands on the bus one poll loop later. A poll counter that is off shifts the `err` pulse by the same number of reads.

Skipped polls show as two bus writes with no read between them. Words taken during a stall show as data out of order in the write log.

// File: rtl/fprog_pkg.sv
// Shared types for the buffered factory-program sequencer.
// Assumes status bit positions fixed by the device protocol.
package fprog_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_SETUP, S_CONFIRM, S_WAIT_RDY,
        S_DATA, S_POLL_WORD, S_EXIT, S_WAIT_END
    } fprog_state_e;

    typedef enum logic [2:0] {
        E_NONE    = 3'd0,
        E_ALIGN   = 3'd1,
        E_RANGE   = 3'd2,
        E_SETUP   = 3'd3,
        E_TIMEOUT = 3'd4,
        E_PROG    = 3'd5
    } fprog_err_e;

    localparam int SR_READY     = 7;
    localparam int SR_SETUP_ERR = 4;
    localparam int SR_WORD_BUSY = 0;
    localparam logic [7:0] SR_ERR_MASK = 8'h3A;
endpackage

// File: rtl/fprog_req_check.sv
// Request screening: flags a start offset that is not buffer aligned and a
// word count that is zero or runs past the end of the block.
// Assumes BUF_WORDS and BLOCK_WORDS are powers of two, BUF_WORDS <= BLOCK_WORDS.
module fprog_req_check #(
    parameter int CW          = 17,
    parameter int BUF_WORDS   = 32,
    parameter int BLOCK_WORDS = 65536
) (
    input  logic [$clog2(BLOCK_WORDS)-1:0] blk_offset,
    input  logic [CW-1:0]                  word_count,
    output logic                           misaligned,
    output logic                           range_bad
);
    localparam int BUF_BITS = $clog2(BUF_WORDS);
    localparam int BLK_BITS = $clog2(BLOCK_WORDS);
    localparam int OW       = ((BLK_BITS > CW) ? BLK_BITS : CW) + 1;

    logic [OW-1:0] end_pos;

    // Compare the last touched position with the block size.
    always_comb begin
        end_pos    = OW'(blk_offset) + OW'(word_count);
        misaligned = |blk_offset[BUF_BITS-1:0];
        range_bad  = (word_count == '0) || (end_pos > OW'(BLOCK_WORDS));
    end
endmodule

// File: rtl/fprog_word_track.sv
// Tracks the position inside the current buffer, the words still to come from
// the stream and the address of the current buffer.
// Assumes one step per data write, padding steps included.
module fprog_word_track #(
    parameter int AW        = 24,
    parameter int CW        = 17,
    parameter int BUF_WORDS = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] word_count,
    input  logic          step,
    output logic [AW-1:0] buf_addr,
    output logic          pad_word,
    output logic          final_word
);
    localparam int IW = $clog2(BUF_WORDS);
    localparam logic [IW-1:0] IDX_LAST = IW'(BUF_WORDS - 1);

    logic [IW-1:0] idx_q;
    logic [CW-1:0] rem_q;

    // Advance position, remaining count and buffer address per written word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            rem_q    <= '0;
            buf_addr <= '0;
        end else if (load) begin
            idx_q    <= '0;
            rem_q    <= word_count;
            buf_addr <= start_addr;
        end else if (step) begin
            idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
            if (idx_q == IDX_LAST)
                buf_addr <= buf_addr + AW'(BUF_WORDS);
            if (rem_q != '0)
                rem_q <= rem_q - 1'b1;
        end
    end

    // A buffer slot is padding once the stream is used up.
    always_comb begin
        pad_word   = (rem_q == '0);
        final_word = (idx_q == IDX_LAST) && (rem_q <= CW'(1));
    end
endmodule

// File: rtl/fprog_poll_timer.sv
// Counts consecutive unsuccessful status reads of one polling loop.
// Assumes the loop owner clears it whenever no loop is active.
module fprog_poll_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic miss,
    output logic last
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_q;

    // Count misses; restart when the loop is left.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (miss && !last)
            cnt_q <= cnt_q + 1'b1;
    end

    // The next miss is the one that exhausts the budget.
    assign last = (cnt_q == TW'(LIMIT - 1));
endmodule

// File: rtl/fprog_seq.sv
// Host sequencer for the buffered factory-program procedure on one block:
// setup and confirm writes, ready poll, polled 32-word buffer writes with
// all-ones padding, an out-of-block terminating write and a final status check.
// Assumes read status is valid on the edge where bus_re is high, and that the
// block is already unlocked.
module fprog_seq
    import fprog_pkg::*;
#(
    parameter int AW            = 24,
    parameter int DW            = 16,
    parameter int CW            = 17,
    parameter int BUF_WORDS     = 32,
    parameter int BLOCK_WORDS   = 65536,
    parameter int TIMEOUT_POLLS = 1000,
    parameter logic [DW-1:0] SETUP_CMD   = 16'h0080,
    parameter logic [DW-1:0] CONFIRM_CMD = 16'h00D0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] word_count,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_valid,
    output logic          wr_ready,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_we,
    output logic          bus_re,
    input  logic [7:0]    bus_rstat,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [2:0]    err_code,
    output logic [7:0]    status_cap
);
    localparam int BLK_BITS = $clog2(BLOCK_WORDS);

    fprog_state_e  state_q;
    logic [AW-1:0] start_q;
    logic          exit_next_q;
    logic          misaligned, range_bad;
    logic          polling, cond_met, word_taken, load;
    logic          pad_word, final_word, poll_last;
    logic [AW-1:0] buf_addr;

    fprog_req_check #(.CW(CW), .BUF_WORDS(BUF_WORDS), .BLOCK_WORDS(BLOCK_WORDS)) req_i (
        .blk_offset (start_addr[BLK_BITS-1:0]),
        .word_count (word_count),
        .misaligned (misaligned),
        .range_bad  (range_bad)
    );

    fprog_word_track #(.AW(AW), .CW(CW), .BUF_WORDS(BUF_WORDS)) track_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .start_addr (start_addr),
        .word_count (word_count),
        .step       (word_taken),
        .buf_addr   (buf_addr),
        .pad_word   (pad_word),
        .final_word (final_word)
    );

    fprog_poll_timer #(.LIMIT(TIMEOUT_POLLS)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!polling),
        .miss  (polling && !cond_met),
        .last  (poll_last)
    );

    // Decode the polling condition and the stream handshake of the current state.
    always_comb begin
        polling    = (state_q == S_WAIT_RDY) || (state_q == S_POLL_WORD) || (state_q == S_WAIT_END);
        cond_met   = (state_q == S_POLL_WORD) ? !bus_rstat[SR_WORD_BUSY] : bus_rstat[SR_READY];
        wr_ready   = (state_q == S_DATA) && !pad_word;
        word_taken = (state_q == S_DATA) && (pad_word || wr_valid);
        load       = (state_q == S_IDLE) && start && !misaligned && !range_bad;
        busy       = (state_q != S_IDLE);
    end

    // Drive the device bus from the state.
    always_comb begin
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_addr  = start_q;
        bus_wdata = '1;
        unique case (state_q)
            S_SETUP:   begin bus_we = 1'b1; bus_wdata = SETUP_CMD; end
            S_CONFIRM: begin bus_we = 1'b1; bus_wdata = CONFIRM_CMD; end
            S_DATA: begin
                bus_we    = word_taken;
                bus_addr  = buf_addr;
                bus_wdata = pad_word ? '1 : wr_data;
            end
            S_EXIT:    begin bus_we = 1'b1; bus_addr = start_q ^ AW'(BLOCK_WORDS); end
            S_WAIT_RDY, S_POLL_WORD, S_WAIT_END: bus_re = 1'b1;
            default: ;
        endcase
    end

    // Step through the procedure and record its outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            start_q     <= '0;
            exit_next_q <= 1'b0;
            done        <= 1'b0;
            err         <= 1'b0;
            err_code    <= E_NONE;
            status_cap  <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start) begin
                    status_cap <= '0;
                    if (misaligned) begin
                        err <= 1'b1; err_code <= E_ALIGN;
                    end else if (range_bad) begin
                        err <= 1'b1; err_code <= E_RANGE;
                    end else begin
                        err_code <= E_NONE;
                        start_q  <= start_addr;
                        state_q  <= S_SETUP;
                    end
                end
                S_SETUP:   state_q <= S_CONFIRM;
                S_CONFIRM: state_q <= S_WAIT_RDY;
                S_WAIT_RDY: begin
                    if (cond_met) begin
                        status_cap <= bus_rstat;
                        if (bus_rstat[SR_SETUP_ERR]) begin
                            err <= 1'b1; err_code <= E_SETUP; state_q <= S_IDLE;
                        end else begin
                            state_q <= S_DATA;
                        end
                    end else if (poll_last) begin
                        status_cap <= bus_rstat;
                        err <= 1'b1; err_code <= E_TIMEOUT; state_q <= S_IDLE;
                    end
                end
                S_DATA: if (word_taken) begin
                    exit_next_q <= final_word;
                    state_q     <= S_POLL_WORD;
                end
                S_POLL_WORD: begin
                    if (cond_met) begin
                        state_q <= exit_next_q ? S_EXIT : S_DATA;
                    end else if (poll_last) begin
                        status_cap <= bus_rstat;
                        err <= 1'b1; err_code <= E_TIMEOUT; state_q <= S_IDLE;
                    end
                end
                S_EXIT: state_q <= S_WAIT_END;
                S_WAIT_END: begin
                    if (cond_met) begin
                        status_cap <= bus_rstat;
                        state_q    <= S_IDLE;
                        if (|(bus_rstat & SR_ERR_MASK)) begin
                            err <= 1'b1; err_code <= E_PROG;
                        end else begin
                            done <= 1'b1; err_code <= E_NONE;
                        end
                    end else if (poll_last) begin
                        status_cap <= bus_rstat;
                        err <= 1'b1; err_code <= E_TIMEOUT; state_q <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fprog_seq_chk.sv
// Protocol checker for fprog_seq, attached through bind.
// Assumes the same reset and clock as the sequencer.
module fprog_seq_chk #(
    parameter int DW = 16,
    parameter logic [DW-1:0] SETUP_CMD = 16'h0080
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [2:0]    err_code,
    input logic          bus_we,
    input logic          bus_re,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] wr_data,
    input logic          wr_valid,
    input logic          wr_ready
);
    // A status read never shares a cycle with a write.
    assert_rd_wr_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));

    // An idle sequencer leaves the bus alone.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_we && !bus_re));

    // Each accepted request opens with the setup write.
    assert_setup_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (bus_we && bus_wdata == SETUP_CMD));

    // Outcome pulses last one cycle and never coincide.
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_err_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);
    assert_outcome_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // A failure always carries a nonzero code.
    assert_err_coded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != 3'd0));

    // A taken stream word goes to the bus in that same cycle.
    assert_word_on_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |-> (bus_we && bus_wdata == wr_data));

    // Words are only offered for while a request is running.
    assert_ready_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (busy && !bus_re));
endmodule

bind fprog_seq fprog_seq_chk #(.DW(DW), .SETUP_CMD(SETUP_CMD)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .err_code  (err_code),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .wr_data   (wr_data),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready)
);

// File: tb/fprog_seq_tb_top.sv
// Directed bench for fprog_seq with a behavioural device and a word source.
module fprog_seq_tb_top;
    localparam int AW = 24, DW = 16, CW = 17, LOGN = 96, POLLS = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] word_count = '0;
    logic [DW-1:0] wr_data;
    logic          wr_valid, wr_ready;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_we, bus_re;
    logic [7:0]    bus_rstat;
    logic          busy, done, err;
    logic [2:0]    err_code;
    logic [7:0]    status_cap;

    fprog_seq #(.AW(AW), .DW(DW), .CW(CW), .BUF_WORDS(32), .BLOCK_WORDS(65536),
                .TIMEOUT_POLLS(POLLS)) dut_i (.*);

    int checks = 0, errors = 0;
    bit finished = 0;

    // Device model controls set by tests.
    logic          clr_req = 1'b0;
    logic          stall = 1'b0, hang = 1'b0;
    logic [7:0]    errb = 8'h00;
    int            pre7 = 3, pre0 = 2, pre7e = 4, feed_n = 0;
    logic [AW-1:0] cur_start = '0;

    // Device model state.
    logic [AW-1:0] log_a [LOGN];
    logic [DW-1:0] log_d [LOGN];
    int nlog, nreads, viol, busy7, busy0, feed_idx, cyc_cnt;
    bit read_since;

    assign bus_rstat = {(busy7 == 0) && !hang, 7'b0} | ((busy0 > 0 || hang) ? 8'h01 : 8'h00) | errb;
    assign wr_valid  = (feed_idx < feed_n) && (!stall || (cyc_cnt % 3 == 0));
    assign wr_data   = 16'(16'h1000 + feed_idx * 3);

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    // Device behaviour and write log.
    always @(posedge clk) begin
        if (clr_req) begin
            nlog <= 0; nreads <= 0; viol <= 0; busy7 <= 0; busy0 <= 0;
            feed_idx <= 0; read_since <= 0;
        end else begin
            if (wr_valid && wr_ready) feed_idx <= feed_idx + 1;
            if (bus_re) begin
                nreads <= nreads + 1; read_since <= 1;
                if (busy7 > 0) busy7 <= busy7 - 1;
                if (busy0 > 0) busy0 <= busy0 - 1;
            end
            if (bus_we) begin
                if (nlog < LOGN) begin log_a[nlog] <= bus_addr; log_d[nlog] <= bus_wdata; end
                nlog <= nlog + 1; read_since <= 0;
                if (nlog >= 2 && (!read_since || busy0 > 0)) viol <= viol + 1;
                if (nlog == 1) busy7 <= pre7;
                else if (nlog >= 2) begin
                    if (bus_addr[23:16] != cur_start[23:16]) busy7 <= pre7e;
                    else busy0 <= pre0;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        @(negedge clk); clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0;
    endtask

    // Issue one request and wait for its outcome pulse; returns cycles taken.
    task automatic run_op(input logic [AW-1:0] sa, input int cnt, input bit poke,
                          output int cyc, output bit got_done, output bit got_err);
        model_clear();
        cur_start = sa; feed_n = cnt;
        start_addr = sa; word_count = CW'(cnt); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 1;
        while (!(done || err) && cyc < 5000) begin
            @(negedge clk); cyc++;
            if (poke && cyc == 5) begin start = 1'b1; start_addr = sa + 4; end
            else start = 1'b0;
        end
        got_done = done; got_err = err;
        if (cyc >= 5000) check(0, "watchdog run", cyc, 0);
    endtask

    // Compare the write log against the expected procedure.
    task automatic check_log(input logic [AW-1:0] sa, input int cnt, input string req);
        int nbuf = (cnt + 31) / 32;
        int total = 3 + nbuf * 32;
        check(nlog == total, {req, " write count"}, nlog, total);
        check(viol == 0, "R6 poll before write", viol, 0);
        check(log_a[0] == sa && log_d[0] == 16'h0080, "R3 setup write", log_d[0], 16'h0080);
        check(log_a[1] == sa && log_d[1] == 16'h00D0, "R3 confirm write", log_d[1], 16'h00D0);
        for (int j = 0; j < nbuf * 32 && j + 2 < LOGN; j++) begin
            logic [AW-1:0] ea = sa + AW'((j / 32) * 32);
            logic [DW-1:0] ed = (j < cnt) ? 16'(16'h1000 + j * 3) : 16'hFFFF;
            if (log_a[j+2] != ea) check(0, "R5 buffer address", log_a[j+2], ea);
            if (log_d[j+2] != ed) check(0, (j < cnt) ? "R11 word order" : "R7 padding", log_d[j+2], ed);
        end
        check(log_a[total-1] == (sa ^ 24'h010000) && log_d[total-1] == 16'hFFFF,
              "R8 exit write", log_a[total-1], sa ^ 24'h010000);
    endtask

    task automatic test_reset();
        check(!busy && !done && !err, "R12 reset outputs", {busy, done, err}, 0);
        check(!wr_ready && !bus_we && !bus_re, "R12 reset bus idle", {wr_ready, bus_we, bus_re}, 0);
    endtask

    task automatic test_one_buffer();
        int c; bit d, e;
        stall = 0; hang = 0; errb = 0;
        run_op(24'h030040, 32, 1, c, d, e);
        check(d && !e && err_code == 0, "R9 clean done", err_code, 0);
        check(status_cap == 8'h80, "R9 status captured", status_cap, 8'h80);
        check_log(24'h030040, 32, "R12 busy start ignored");
        @(negedge clk);
        check(!busy && !done, "R12 done single pulse", {busy, done}, 0);
    endtask

    task automatic test_two_buffers_stall();
        int c; bit d, e;
        stall = 1; hang = 0; errb = 0;
        run_op(24'h051FC0, 40, 0, c, d, e);
        check(d && !e, "R7 two buffers done", {d, e}, 2);
        check(feed_idx == 40, "R11 words consumed", feed_idx, 40);
        check_log(24'h051FC0, 40, "R7");
        stall = 0;
    endtask

    task automatic test_misaligned();
        int c; bit d, e;
        run_op(24'h030044, 8, 0, c, d, e);
        check(e && err_code == 1, "R1 align code", err_code, 1);
        check(c == 1, "R1 immediate refusal", c, 1);
        check(nlog == 0 && nreads == 0, "R1 no bus cycle", nlog + nreads, 0);
    endtask

    task automatic test_range();
        int c; bit d, e;
        run_op(24'h03FFE0, 40, 0, c, d, e);
        check(e && err_code == 2, "R2 crossing code", err_code, 2);
        check(nlog == 0 && nreads == 0, "R2 no bus cycle", nlog + nreads, 0);
        run_op(24'h030000, 0, 0, c, d, e);
        check(e && err_code == 2, "R2 zero count code", err_code, 2);
    endtask

    task automatic test_setup_fail();
        int c; bit d, e;
        errb = 8'h10;
        run_op(24'h030000, 16, 0, c, d, e);
        check(e && err_code == 3, "R4 setup error code", err_code, 3);
        check(status_cap == 8'h90, "R4 status captured", status_cap, 8'h90);
        check(nlog == 2, "R4 no data write", nlog, 2);
        errb = 0;
    endtask

    task automatic test_prog_fail();
        int c; bit d, e;
        errb = 8'h20;
        run_op(24'h030000, 5, 0, c, d, e);
        check(e && !d && err_code == 5, "R9 program error code", err_code, 5);
        check(status_cap == 8'hA0, "R9 error status captured", status_cap, 8'hA0);
        errb = 0;
    endtask

    task automatic test_timeout();
        int c; bit d, e;
        hang = 1;
        run_op(24'h030000, 4, 0, c, d, e);
        check(e && err_code == 4, "R10 timeout code", err_code, 4);
        check(nreads == POLLS, "R10 read budget", nreads, POLLS);
        hang = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_one_buffer();
        test_two_buffers_stall();
        test_misaligned();
        test_range();
        test_setup_fail();
        test_prog_fail();
        test_timeout();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule